// File: doc/BRIEF.md
# Smart Card Contact Activation Sequencer

This block is the control core of a smart card interface. It waits in an idle mode with every card contact switched off. When the host pulls its active-low session command low, it powers the contacts up in a fixed order with timed gaps between the steps. The order is supply first, then programming voltage together with the card I/O path, then clock and reset. Once the card is powered, a host I/O level chooses between a read mode, where the host-side I/O driver is on, and a write mode, where data flows toward the card.

The block powers the card down in the reverse order in four cases: the host releases the command, the host-supply alarm fires, the main supply falls out of range, or a fault flag rises. After a fault it parks in a fault mode and holds its status line low until the host lets go of the command. It also decodes a pair of card-presence inputs into a single detect line. All timing comes from a microsecond prescaler, so the delays scale with the system clock through one parameter. All asynchronous inputs pass through a parameterised synchronizer.

Top module: `sc_act_seq`

## Requirements
- R1: After reset the block is in IDLE (mode code 0): vcc_en_o, vpp_en_o, io_en_o, clk_en_o, rst_en_o and host_oe_o are all 0.
- R2: A session starts (vcc_en_o rises, mode code 1) only when cmd_n_i is 0 and host_io_i is 1, with vdd_ok_i at 1 and alarm_i at 0. With host_io_i at 0 the command is refused.
- R3: Contacts switch on in a fixed order: vcc_en_o first, then vpp_en_o and io_en_o together, and last clk_en_o and rst_en_o together.
- R4: The gap from vcc_en_o rising to vpp_en_o rising is T_SUP_US*CLKS_PER_US cycles. The gap from vpp_en_o rising to clk_en_o rising is T_VPP_US*CLKS_PER_US cycles.
- R5: When activation completes, the mode is READ (code 2, host_oe_o=1, io_dir_o=0) while host_io_i is 1, and WRITE (code 3, host_oe_o=0, io_dir_o=1) while host_io_i is 0. The mode follows host_io_i for as long as the session lasts.
- R6: Releasing cmd_n_i to 1 in an active mode enters DEACT (code 4). Clock and reset go off first. After T_OFF_US*CLKS_PER_US cycles programming voltage and I/O go off. After the same gap again the supply goes off, and the block returns to IDLE in that same cycle.
- R7: alarm_i at 1 or vdd_ok_i at 0 in any active mode forces DEACT on the next decision. This takes priority over a step timer expiring in the same cycle.
- R8: While alarm_i is 1 or vdd_ok_i is 0, the block stays in IDLE even with the command asserted.
- R9: A fault flag in an active mode runs the deactivation sequence and then enters FAULT (code 5) with every contact off. FAULT and a low ok_o persist until cmd_n_i returns to 1, and the block then goes back to IDLE.
- R10: detect_o is 1 exactly when pres_i is 1 and pres_n_i is 0.
- R11: ok_o is 1 when no fault flag is set and no fault is latched. A fault flag in IDLE pulls ok_o low without changing the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_n_i | input | 1 | Session command, active low |
| host_io_i | input | 1 | Host I/O line level; start guard and READ/WRITE select |
| pres_i | input | 1 | Card presence contact, active high |
| pres_n_i | input | 1 | Card presence contact, active low |
| vdd_ok_i | input | 1 | Main supply within range |
| alarm_i | input | 1 | Host-supply alarm, active high |
| fault_i | input | NUM_FAULTS | Hardware fault flags, active high |
| vcc_en_o | output | 1 | Card supply enable |
| vpp_en_o | output | 1 | Programming voltage enable |
| io_en_o | output | 1 | Card I/O path enable |
| clk_en_o | output | 1 | Card clock enable |
| rst_en_o | output | 1 | Card reset line enable |
| io_dir_o | output | 1 | 1 = host to card (WRITE), 0 otherwise |
| host_oe_o | output | 1 | Host-side I/O driver enable (READ) |
| detect_o | output | 1 | Card present |
| ok_o | output | 1 | No hardware fault |
| mode_o | output | 3 | Mode code: 0 IDLE, 1 ACT, 2 READ, 3 WRITE, 4 DEACT, 5 FAULT |

## Verification
Two events can reach the controller on the same clock edge: a step timer expiring during activation and a supply abort. The bench waits for the supply enable to rise. It then counts forward and raises the alarm so that, after the synchronizer latency, the alarm arrives on exactly the edge where the first timer finishes. It then checks that the programming voltage never switched on and that the mode is DEACT. If the timer had won, the programming voltage would stay high for a full deactivation gap, and the check would see it.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

   typedef enum logic [2:0] {
      MODE_IDLE  = 3'd0,
      MODE_ACT   = 3'd1,
      MODE_READ  = 3'd2,
      MODE_WRITE = 3'd3,
      MODE_DEACT = 3'd4,
      MODE_FAULT = 3'd5
   } sc_mode_e;

   typedef struct packed {
      logic vcc;
      logic vpp;
      logic io;
      logic clk;
      logic rst;
   } sc_contacts_t;

   localparam sc_contacts_t CONTACTS_OFF = '0;

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
   parameter int unsigned W       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("sc_sync: STAGES must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("sc_sync: W must be at least 1");
   end

   logic [W-1:0] chain_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= RST_VAL;
            else         chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[g] <= RST_VAL;
            else         chain_q[g] <= chain_q[g-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sc_us_timer.sv
module sc_us_timer #(
   parameter int unsigned CLKS_PER_US = 50,
   parameter int unsigned DW          = 7
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [DW-1:0] dly_i,
   output logic          done_o
);

   localparam int unsigned PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
   localparam logic [PW-1:0] PRE_TOP = PW'(CLKS_PER_US - 1);

   if (CLKS_PER_US < 1) begin : g_bad_rate
      $error("sc_us_timer: CLKS_PER_US must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("sc_us_timer: DW must be at least 1");
   end

   logic [PW-1:0] pre_q;
   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         pre_q <= PRE_TOP;
         cnt_q <= dly_i;
      end else if (cnt_q != '0) begin
         if (pre_q == '0) begin
            pre_q <= PRE_TOP;
            cnt_q <= cnt_q - DW'(1);
         end else begin
            pre_q <= pre_q - PW'(1);
         end
      end
   end

   assign done_o = (cnt_q == DW'(1)) && (pre_q == '0);

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !load_i) |=> !done_o); // R4

   AST_CNT_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && cnt_q != '0) |=> (cnt_q <= $past(cnt_q))); // R4

endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
   import sc_seq_pkg::*;
#(
   parameter int unsigned DW        = 7,
   parameter int unsigned T_SUP_US  = 16,
   parameter int unsigned T_VPP_US  = 64,
   parameter int unsigned T_OFF_US  = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cmd_n_i,
   input  logic          host_io_i,
   input  logic          vdd_ok_i,
   input  logic          alarm_i,
   input  logic          flt_any_i,
   input  logic          tmr_done_i,
   output logic          tmr_load_o,
   output logic [DW-1:0] tmr_dly_o,
   output sc_contacts_t  con_o,
   output sc_mode_e      mode_o,
   output logic          flt_latched_o
);

   localparam logic [DW-1:0] D_SUP = DW'(T_SUP_US);
   localparam logic [DW-1:0] D_VPP = DW'(T_VPP_US);
   localparam logic [DW-1:0] D_OFF = DW'(T_OFF_US);

   sc_mode_e     state_q, state_d;
   logic         step_q, step_d;
   sc_contacts_t con_q, con_d;
   logic         flt_q, flt_d;

   logic supply_bad, abort, active, start_ok;

   assign supply_bad = alarm_i | ~vdd_ok_i;
   assign abort      = supply_bad | flt_any_i | cmd_n_i;
   assign active     = (state_q == MODE_ACT) || (state_q == MODE_READ) ||
                       (state_q == MODE_WRITE);
   assign start_ok   = ~cmd_n_i & host_io_i & ~supply_bad & ~flt_any_i;

   always_comb begin
      state_d    = state_q;
      step_d     = step_q;
      con_d      = con_q;
      flt_d      = flt_q;
      tmr_load_o = 1'b0;
      tmr_dly_o  = D_OFF;
      unique case (state_q)
         MODE_IDLE: begin
            flt_d = 1'b0;
            if (start_ok) begin
               state_d    = MODE_ACT;
               step_d     = 1'b0;
               con_d.vcc  = 1'b1;
               tmr_load_o = 1'b1;
               tmr_dly_o  = D_SUP;
            end
         end
         MODE_ACT, MODE_READ, MODE_WRITE: begin
            if (abort) begin
               state_d    = MODE_DEACT;
               step_d     = 1'b0;
               con_d.clk  = 1'b0;
               con_d.rst  = 1'b0;
               flt_d      = flt_q | flt_any_i;
               tmr_load_o = 1'b1;
               tmr_dly_o  = D_OFF;
            end else if (state_q == MODE_ACT) begin
               if (tmr_done_i) begin
                  if (!step_q) begin
                     step_d     = 1'b1;
                     con_d.vpp  = 1'b1;
                     con_d.io   = 1'b1;
                     tmr_load_o = 1'b1;
                     tmr_dly_o  = D_VPP;
                  end else begin
                     con_d.clk = 1'b1;
                     con_d.rst = 1'b1;
                     state_d   = host_io_i ? MODE_READ : MODE_WRITE;
                  end
               end
            end else begin
               state_d = host_io_i ? MODE_READ : MODE_WRITE;
            end
         end
         MODE_DEACT: begin
            flt_d = flt_q | flt_any_i;
            if (tmr_done_i) begin
               if (!step_q) begin
                  step_d     = 1'b1;
                  con_d.vpp  = 1'b0;
                  con_d.io   = 1'b0;
                  tmr_load_o = 1'b1;
                  tmr_dly_o  = D_OFF;
               end else begin
                  con_d   = CONTACTS_OFF;
                  state_d = (flt_q | flt_any_i) ? MODE_FAULT : MODE_IDLE;
               end
            end
         end
         MODE_FAULT: begin
            con_d = CONTACTS_OFF;
            if (cmd_n_i) begin
               state_d = MODE_IDLE;
               flt_d   = 1'b0;
            end
         end
         default: begin
            state_d = MODE_IDLE;
            con_d   = CONTACTS_OFF;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= MODE_IDLE;
         step_q  <= 1'b0;
         con_q   <= CONTACTS_OFF;
         flt_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
         con_q   <= con_d;
         flt_q   <= flt_d;
      end
   end

   assign con_o         = con_q;
   assign mode_o        = state_q;
   assign flt_latched_o = flt_q;

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == MODE_IDLE) |-> (con_q == CONTACTS_OFF)); // R1

   AST_VPP_NEEDS_VCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (con_q.vpp || con_q.io) |-> con_q.vcc); // R3

   AST_CLK_NEEDS_VPP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (con_q.clk || con_q.rst) |-> (con_q.vpp && con_q.io)); // R3

   AST_SUPPLY_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && supply_bad) |=> (state_q == MODE_DEACT)); // R7

   AST_BLOCKED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == MODE_IDLE && supply_bad) |=> (state_q == MODE_IDLE)); // R8

   AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == MODE_FAULT && !cmd_n_i) |=> (state_q == MODE_FAULT)); // R9

endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq
   import sc_seq_pkg::*;
#(
   parameter int unsigned CLKS_PER_US = 50,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned T_SUP_US    = 16,
   parameter int unsigned T_VPP_US    = 64,
   parameter int unsigned T_OFF_US    = 4,
   parameter int unsigned NUM_FAULTS  = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cmd_n_i,
   input  logic                  host_io_i,
   input  logic                  pres_i,
   input  logic                  pres_n_i,
   input  logic                  vdd_ok_i,
   input  logic                  alarm_i,
   input  logic [NUM_FAULTS-1:0] fault_i,
   output logic                  vcc_en_o,
   output logic                  vpp_en_o,
   output logic                  io_en_o,
   output logic                  clk_en_o,
   output logic                  rst_en_o,
   output logic                  io_dir_o,
   output logic                  host_oe_o,
   output logic                  detect_o,
   output logic                  ok_o,
   output logic [2:0]            mode_o
);

   localparam int unsigned T_MAX0 = (T_SUP_US > T_VPP_US) ? T_SUP_US : T_VPP_US;
   localparam int unsigned T_MAX  = (T_MAX0 > T_OFF_US) ? T_MAX0 : T_OFF_US;
   localparam int unsigned DW     = $clog2(T_MAX + 1);
   localparam int unsigned SW     = 6 + NUM_FAULTS;
   localparam logic [SW-1:0] SYNC_RST =
      {{NUM_FAULTS{1'b0}}, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

   if (T_SUP_US < 1 || T_VPP_US < 1 || T_OFF_US < 1) begin : g_bad_delay
      $error("sc_act_seq: every delay must be at least 1 us");
   end
   if (NUM_FAULTS < 1) begin : g_bad_faults
      $error("sc_act_seq: NUM_FAULTS must be at least 1");
   end

   logic [SW-1:0]         raw_in, syn_in;
   logic                  cmd_n_s, host_io_s, vdd_ok_s, alarm_s, pres_s, pres_n_s;
   logic [NUM_FAULTS-1:0] fault_s;
   logic                  flt_any, flt_latched;
   logic                  tmr_load, tmr_done;
   logic [DW-1:0]         tmr_dly;
   sc_contacts_t          con;
   sc_mode_e              mode;

   assign raw_in = {fault_i, pres_n_i, pres_i, alarm_i, vdd_ok_i, host_io_i, cmd_n_i};

   sc_sync #(
      .W       (SW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in),
      .q_o    (syn_in)
   );

   assign {fault_s, pres_n_s, pres_s, alarm_s, vdd_ok_s, host_io_s, cmd_n_s} = syn_in;
   assign flt_any = |fault_s;

   sc_us_timer #(
      .CLKS_PER_US (CLKS_PER_US),
      .DW          (DW)
   ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (tmr_load),
      .dly_i  (tmr_dly),
      .done_o (tmr_done)
   );

   sc_seq_fsm #(
      .DW       (DW),
      .T_SUP_US (T_SUP_US),
      .T_VPP_US (T_VPP_US),
      .T_OFF_US (T_OFF_US)
   ) u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .cmd_n_i       (cmd_n_s),
      .host_io_i     (host_io_s),
      .vdd_ok_i      (vdd_ok_s),
      .alarm_i       (alarm_s),
      .flt_any_i     (flt_any),
      .tmr_done_i    (tmr_done),
      .tmr_load_o    (tmr_load),
      .tmr_dly_o     (tmr_dly),
      .con_o         (con),
      .mode_o        (mode),
      .flt_latched_o (flt_latched)
   );

   assign vcc_en_o  = con.vcc;
   assign vpp_en_o  = con.vpp;
   assign io_en_o   = con.io;
   assign clk_en_o  = con.clk;
   assign rst_en_o  = con.rst;
   assign host_oe_o = (mode == MODE_READ);
   assign io_dir_o  = (mode == MODE_WRITE);
   assign detect_o  = pres_s & ~pres_n_s;
   assign ok_o      = ~flt_any & ~flt_latched;
   assign mode_o    = mode;

   AST_HOST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(host_oe_o && io_dir_o)); // R5

   AST_FAULT_NOT_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == MODE_FAULT) |-> !ok_o); // R9

endmodule

// File: tb/sc_act_seq_tb.sv
module sc_act_seq_tb;

   localparam int C    = 2;
   localparam int S    = 2;
   localparam int TSUP = 16;
   localparam int TVPP = 64;
   localparam int TOFF = 2;
   localparam int NF   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_n = 1'b1, host_io = 1'b1, pres = 1'b0, pres_n = 1'b1;
   logic          vdd_ok = 1'b1, alarm = 1'b0;
   logic [NF-1:0] fault = '0;
   logic          vcc_en, vpp_en, io_en, clk_en, rst_en, io_dir, host_oe, detect, ok;
   logic [2:0]    mode;

   int  checks = 0;
   int  errs   = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   sc_act_seq #(
      .CLKS_PER_US (C),
      .SYNC_STAGES (S),
      .T_SUP_US    (TSUP),
      .T_VPP_US    (TVPP),
      .T_OFF_US    (TOFF),
      .NUM_FAULTS  (NF)
   ) u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .cmd_n_i   (cmd_n),
      .host_io_i (host_io),
      .pres_i    (pres),
      .pres_n_i  (pres_n),
      .vdd_ok_i  (vdd_ok),
      .alarm_i   (alarm),
      .fault_i   (fault),
      .vcc_en_o  (vcc_en),
      .vpp_en_o  (vpp_en),
      .io_en_o   (io_en),
      .clk_en_o  (clk_en),
      .rst_en_o  (rst_en),
      .io_dir_o  (io_dir),
      .host_oe_o (host_oe),
      .detect_o  (detect),
      .ok_o      (ok),
      .mode_o    (mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic sig(input int w);
      case (w)
         0:       return vcc_en;
         1:       return vpp_en;
         2:       return clk_en;
         3:       return mode == 3'd0;
         4:       return mode == 3'd5;
         default: return 1'b0;
      endcase
   endfunction

   task automatic wait_for(input int w, input logic v, output int n);
      n = 0;
      while (sig(w) !== v && n < 4000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic go_idle();
      int n;
      cmd_n = 1'b1; alarm = 1'b0; vdd_ok = 1'b1; host_io = 1'b1; fault = '0;
      wait_for(3, 1'b1, n);
      repeat (S + 3) @(negedge clk);
   endtask

   task automatic activate();
      int n;
      host_io = 1'b1;
      cmd_n   = 1'b0;
      wait_for(2, 1'b1, n);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int n;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk("R1 vcc", vcc_en, 0);
      chk("R1 vpp", vpp_en, 0);
      chk("R1 clk", clk_en, 0);
      chk("R1 host_oe", host_oe, 0);
      chk("R1 mode", mode, 0);
      rst_n = 1'b1;
      repeat (S + 3) @(negedge clk);
      chk("R1 io after reset", io_en, 0);
      chk("R1 rst after reset", rst_en, 0);
      chk("R11 ok idle", ok, 1);

      // Activation timing and order: R3, R4, R5
      cmd_n = 1'b0;
      wait_for(0, 1'b1, n);
      chk("R2 act mode", mode, 1);
      chk("R3 vpp off at vcc", vpp_en, 0);
      wait_for(1, 1'b1, n);
      chk("R4 supply gap", n, TSUP * C);
      chk("R3 io with vpp", io_en, 1);
      chk("R3 clk after vpp", clk_en, 0);
      wait_for(2, 1'b1, n);
      chk("R4 vpp gap", n, TVPP * C);
      chk("R3 rst with clk", rst_en, 1);
      chk("R5 read mode", mode, 2);
      chk("R5 read host_oe", host_oe, 1);
      chk("R5 read io_dir", io_dir, 0);
      host_io = 1'b0;
      repeat (S + 2) @(negedge clk);
      chk("R5 write mode", mode, 3);
      chk("R5 write io_dir", io_dir, 1);
      chk("R5 write host_oe", host_oe, 0);
      host_io = 1'b1;
      repeat (S + 2) @(negedge clk);
      chk("R5 back to read", mode, 2);

      // Normal deactivation: R6
      cmd_n = 1'b1;
      wait_for(2, 1'b0, n);
      chk("R6 deact mode", mode, 4);
      chk("R6 rst off with clk", rst_en, 0);
      chk("R6 vpp still on", vpp_en, 1);
      wait_for(1, 1'b0, n);
      chk("R6 first gap", n, TOFF * C);
      chk("R6 io off with vpp", io_en, 0);
      chk("R6 vcc still on", vcc_en, 1);
      wait_for(0, 1'b0, n);
      chk("R6 second gap", n, TOFF * C);
      chk("R6 idle after vcc off", mode, 0);
      repeat (S + 3) @(negedge clk);

      // Sweep of start conditions: R2, R8
      for (int i = 0; i < 16; i++) begin
         logic exp_start;
         cmd_n   = i[0];
         host_io = i[1];
         vdd_ok  = i[2];
         alarm   = i[3];
         exp_start = !i[0] && i[1] && i[2] && !i[3];
         repeat (S + 4) @(negedge clk);
         chk(exp_start ? "R2 start" : (i[3] || !i[2]) ? "R8 blocked" : "R2 refused",
             vcc_en, exp_start);
         chk("R2 mode after sweep step", mode, exp_start ? 1 : 0);
         go_idle();
      end

      // Supply aborts in READ: R7, then blocking: R8
      for (int cause = 0; cause < 2; cause++) begin
         activate();
         if (cause == 0) vdd_ok = 1'b0;
         else            alarm  = 1'b1;
         wait_for(2, 1'b0, n);
         chk("R7 abort latency", n, S + 1);
         chk("R7 abort mode", mode, 4);
         wait_for(3, 1'b1, n);
         repeat (10) @(negedge clk);
         chk("R8 stays idle", mode, 0);
         chk("R8 no vcc", vcc_en, 0);
         go_idle();
      end

      // Timer expiry and alarm on the same edge: R7 priority
      cmd_n = 1'b0;
      wait_for(0, 1'b1, n);
      repeat (TSUP * C - S - 1) @(negedge clk);
      alarm = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 race vpp", vpp_en, 0);
      chk("R7 race mode", mode, 4);
      repeat (2) @(negedge clk);
      chk("R7 race vpp later", vpp_en, 0);
      go_idle();

      // Fault in active mode: R9, R11
      activate();
      fault = 2'b10;
      repeat (S + 1) @(negedge clk);
      chk("R11 ok low on fault", ok, 0);
      wait_for(4, 1'b1, n);
      chk("R9 fault mode", mode, 5);
      chk("R9 vcc off", vcc_en, 0);
      chk("R9 clk off", clk_en, 0);
      fault = '0;
      repeat (S + 4) @(negedge clk);
      chk("R9 held in fault", mode, 5);
      chk("R9 ok latched low", ok, 0);
      cmd_n = 1'b1;
      repeat (S + 3) @(negedge clk);
      chk("R9 idle after release", mode, 0);
      chk("R11 ok restored", ok, 1);

      // Fault in IDLE: R11
      fault = 2'b01;
      repeat (S + 2) @(negedge clk);
      chk("R11 idle fault ok", ok, 0);
      chk("R11 idle fault mode", mode, 0);
      fault = '0;
      repeat (S + 2) @(negedge clk);
      chk("R11 idle fault cleared", ok, 1);

      // Presence decode sweep: R10
      for (int p = 0; p < 4; p++) begin
         pres   = p[0];
         pres_n = p[1];
         repeat (S + 2) @(negedge clk);
         chk("R10 detect", detect, (p[0] && !p[1]) ? 1 : 0);
      end

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule